// File: doc/BRIEF.md
# Prompt In-Phase Correlation Path with Front-End Duty Monitor

This block is one in-phase prompt correlation path of a satellite-navigation baseband channel. Each enabled sample cycle it takes a two-bit front-end sample (a sign bit and a magnitude bit) and weights it. It then multiplies the weight by a carrier mixer level and by the current code chip, and adds the product to a signed running sum. A dump strobe from the code timing closes the integration period. On that cycle the sum and the number of samples are copied into output registers, and both running values restart from zero.

Test controls turn the path into a front-end monitor. A global override forces the carrier level to +1, and a per-path override forces the code multiplier to +1. A monitor mode selects a sign-only weighting or a magnitude-only weighting. With both mixers transparent, the latched sum ACC and the latched count N give the sign duty as (N + ACC) / 2N. In magnitude mode they give the magnitude duty as -(N + ACC) / 2N.

Top module: `corr_prompt_chan`

## Requirements
- R1: While reset is asserted and after its release, `acc_q`, `cnt_q` and `dump_vld` are zero until the first dump.
- R2: When `mon_mode` is 2'b00 or 2'b11 (normal), the sample weight is +1 or +3 when `smp_sign` is 1, and -1 or -3 when it is 0. The magnitude 3 is used when `smp_mag` is 1.
- R3: `carr_lvl` encodes the carrier level. Bit 1 gives the sign (1 = negative) and bit 0 gives the size (1 = 2): 2'b00 = +1, 2'b01 = +2, 2'b10 = -1, 2'b11 = -2. When `carr_mix_off` is 0, the weight is multiplied by this level.
- R4: When `code_off` is 0, the product is multiplied by +1 for `code_chip` = 1 and by -1 for `code_chip` = 0. When `code_off` is 1, the multiplier is +1 whatever the value of `code_chip`.
- R5: When `carr_mix_off` is 1, the carrier multiplier is +1 whatever the value of `carr_lvl`.
- R6: When `mon_mode` is 2'b01 (sign monitor), the weight is +1 for `smp_sign` = 1 and -1 for `smp_sign` = 0, whatever the value of `smp_mag`.
- R7: When `mon_mode` is 2'b10 (magnitude monitor), the weight is -3 for `smp_mag` = 1 and -1 for `smp_mag` = 0, whatever the value of `smp_sign`.
- R8: When `dump` is 1 at a clock edge, `acc_q` takes the running sum including that cycle's product, and the running sum restarts at zero. The new value is visible after that edge and holds until the next dump.
- R9: `cnt_q` takes the number of `smp_en` cycles in the period, including the dump cycle, with the same timing as `acc_q`.
- R10: `dump_vld` is 1 for exactly the one cycle after each clock edge with `dump` = 1, and 0 otherwise.
- R11: A cycle with `smp_en` = 0 adds nothing to the sum or to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample valid this cycle |
| smp_sign | input | 1 | Front-end sign bit (1 = positive) |
| smp_mag | input | 1 | Front-end magnitude bit (1 = large) |
| carr_lvl | input | 2 | Carrier mixer level code |
| carr_mix_off | input | 1 | Force carrier multiplier to +1 |
| code_chip | input | 1 | Code chip (1 = +1, 0 = -1) |
| code_off | input | 1 | Force code multiplier to +1 |
| mon_mode | input | 2 | Weighting: normal, sign monitor, magnitude monitor |
| dump | input | 1 | End of integration period |
| acc_q | output | ACC_W | Latched signed sum of the last period |
| cnt_q | output | CNT_W | Latched sample count of the last period |
| dump_vld | output | 1 | New latched values present |

## Verification
The main corner is the dump cycle itself. A design that dropped the dump-cycle product would latch a sum one sample short. A design that failed to clear would carry that sample into the next period and break N + ACC as an even number. Back-to-back dumps and one-sample periods expose both errors. The bench also runs dumps with `smp_en` low, which shows whether an idle cycle is wrongly counted. Overrides are driven with deliberately hostile `carr_lvl`, `code_chip`, `smp_mag` and `smp_sign` values. A leaky override would then shift the monitor sums away from exact -1/-3 or ±1 totals. Long all-high magnitude periods check the negative sign handling of the wide sum.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_SIGN = 2'b01,
    MODE_MAG  = 2'b10,
    MODE_RSVD = 2'b11
  } mon_mode_e;

  localparam int WGT_W  = 3;
  localparam int PROD_W = 4;
endpackage

// File: rtl/corr_rst_sync.sv
module corr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/corr_weight.sv
module corr_weight
  import corr_pkg::*;
(
  input  logic                     smp_sign,
  input  logic                     smp_mag,
  input  mon_mode_e                mode,
  output logic signed [WGT_W-1:0]  wgt
);
  always_comb begin
    unique case (mode)
      MODE_SIGN: wgt = smp_sign ? 3'sd1 : -3'sd1;
      MODE_MAG:  wgt = smp_mag ? -3'sd3 : -3'sd1;
      default: begin
        if (smp_sign) wgt = smp_mag ? 3'sd3 : 3'sd1;
        else          wgt = smp_mag ? -3'sd3 : -3'sd1;
      end
    endcase
  end
endmodule

// File: rtl/corr_mixer.sv
module corr_mixer
  import corr_pkg::*;
(
  input  logic signed [WGT_W-1:0]  wgt,
  input  logic [1:0]               carr_lvl,
  input  logic                     carr_mix_off,
  input  logic                     code_chip,
  input  logic                     code_off,
  output logic signed [PROD_W-1:0] prod
);
  logic signed [PROD_W-1:0] wgt_x;
  logic signed [PROD_W-1:0] carr_x;
  logic signed [PROD_W-1:0] carr_prod;
  logic                     code_neg;

  always_comb begin
    wgt_x = {{(PROD_W-WGT_W){wgt[WGT_W-1]}}, wgt};
    if (carr_mix_off) begin
      carr_x = 4'sd1;
    end else begin
      unique case (carr_lvl)
        2'b00:   carr_x = 4'sd1;
        2'b01:   carr_x = 4'sd2;
        2'b10:   carr_x = -4'sd1;
        default: carr_x = -4'sd2;
      endcase
    end
    carr_prod = wgt_x * carr_x;
    code_neg  = !code_off && !code_chip;
    prod      = code_neg ? -carr_prod : carr_prod;
  end
endmodule

// File: rtl/corr_accum.sv
module corr_accum
  import corr_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_en,
  input  logic signed [PROD_W-1:0] prod,
  input  logic                     dump,
  output logic signed [ACC_W-1:0]  acc_q,
  output logic [CNT_W-1:0]         cnt_q,
  output logic                     dump_vld
);
  localparam int ACC_EXT = ACC_W - PROD_W;

  logic signed [ACC_W-1:0] run_acc, run_acc_n, acc_sum, prod_x;
  logic [CNT_W-1:0]        run_cnt, run_cnt_n, cnt_sum;

  always_comb begin
    prod_x    = smp_en ? {{ACC_EXT{prod[PROD_W-1]}}, prod} : '0;
    acc_sum   = run_acc + prod_x;
    cnt_sum   = run_cnt + {{(CNT_W-1){1'b0}}, smp_en};
    run_acc_n = dump ? '0 : acc_sum;
    run_cnt_n = dump ? '0 : cnt_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_acc <= '0;
      run_cnt <= '0;
    end else begin
      run_acc <= run_acc_n;
      run_cnt <= run_cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (dump) begin
      acc_q <= acc_sum;
      cnt_q <= cnt_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dump_vld <= 1'b0;
    else        dump_vld <= dump;
  end
endmodule

// File: rtl/corr_prompt_chan.sv
module corr_prompt_chan
  import corr_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    smp_sign,
  input  logic                    smp_mag,
  input  logic [1:0]              carr_lvl,
  input  logic                    carr_mix_off,
  input  logic                    code_chip,
  input  logic                    code_off,
  input  logic [1:0]              mon_mode,
  input  logic                    dump,
  output logic signed [ACC_W-1:0] acc_q,
  output logic [CNT_W-1:0]        cnt_q,
  output logic                    dump_vld
);
  logic                     rst_sync_n;
  logic signed [WGT_W-1:0]  wgt_w;
  logic signed [PROD_W-1:0] prod_w;
  mon_mode_e                mode_w;

  assign mode_w = mon_mode_e'(mon_mode);

  corr_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  corr_weight wgt_i (
    .smp_sign(smp_sign), .smp_mag(smp_mag), .mode(mode_w), .wgt(wgt_w)
  );

  corr_mixer mix_i (
    .wgt(wgt_w), .carr_lvl(carr_lvl), .carr_mix_off(carr_mix_off),
    .code_chip(code_chip), .code_off(code_off), .prod(prod_w)
  );

  corr_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) acc_i (
    .clk(clk), .rst_n(rst_sync_n), .smp_en(smp_en), .prod(prod_w),
    .dump(dump), .acc_q(acc_q), .cnt_q(cnt_q), .dump_vld(dump_vld)
  );
endmodule

// File: rtl/corr_prompt_chan_chk.sv
module corr_prompt_chan_chk #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dump,
  input logic                    smp_en,
  input logic [1:0]              mode,
  input logic                    carr_off,
  input logic                    code_off,
  input logic signed [3:0]       prod,
  input logic signed [ACC_W-1:0] acc_q,
  input logic [CNT_W-1:0]        cnt_q,
  input logic                    dump_vld
);
  AST_VLD_AFTER_DUMP: assert property (@(posedge clk) disable iff (!rst_n) dump |=> dump_vld); // R10
  AST_VLD_ONLY_DUMP: assert property (@(posedge clk) disable iff (!rst_n) !dump |=> !dump_vld); // R10
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) !dump |=> ($stable(acc_q) && $stable(cnt_q))); // R8
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (dump && smp_en) |=> (cnt_q != '0)); // R9
  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (prod != 4'sd0) && (prod <= 4'sd6) && (prod >= -4'sd6)); // R3
  AST_SIGN_UNIT: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b01 && carr_off && code_off) |-> (prod == 4'sd1 || prod == -4'sd1)); // R6
  AST_MAG_NEG: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10 && carr_off && code_off) |-> (prod == -4'sd1 || prod == -4'sd3)); // R7
  AST_TRANSPARENT_NORM: assert property (@(posedge clk) disable iff (!rst_n) ((mode == 2'b00 || mode == 2'b11) && carr_off && code_off) |-> (prod == 4'sd1 || prod == -4'sd1 || prod == 4'sd3 || prod == -4'sd3)); // R5
endmodule

bind corr_prompt_chan corr_prompt_chan_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .dump(dump), .smp_en(smp_en),
  .mode(mon_mode), .carr_off(carr_mix_off), .code_off(code_off),
  .prod(prod_w), .acc_q(acc_q), .cnt_q(cnt_q), .dump_vld(dump_vld)
);

// File: tb/corr_prompt_chan_tb_top.sv
module corr_prompt_chan_tb_top;
  localparam int ACC_W = 16;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_en, smp_sign, smp_mag, carr_mix_off, code_chip, code_off, dump;
  logic [1:0] carr_lvl, mon_mode;
  logic signed [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic dump_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic signed [ACC_W-1:0] m_acc, e_acc;
  logic [CNT_W-1:0] m_cnt, e_cnt;
  logic e_vld;

  always #2.5 clk = ~clk;

  corr_prompt_chan #(.ACC_W(ACC_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_sign(smp_sign),
    .smp_mag(smp_mag), .carr_lvl(carr_lvl), .carr_mix_off(carr_mix_off),
    .code_chip(code_chip), .code_off(code_off), .mon_mode(mon_mode),
    .dump(dump), .acc_q(acc_q), .cnt_q(cnt_q), .dump_vld(dump_vld)
  );

  function automatic int ref_prod(bit s, bit m, bit [1:0] md, bit [1:0] cl,
                                  bit coff, bit chip, bit kof);
    int w, c, k;
    if (md == 2'b01)      w = s ? 1 : -1;
    else if (md == 2'b10) w = m ? -3 : -1;
    else                  w = (s ? 1 : -1) * (m ? 3 : 1);
    if (coff) c = 1;
    else      c = (cl[1] ? -1 : 1) * (cl[0] ? 2 : 1);
    k = (kof || chip) ? 1 : -1;
    return w * c * k;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    check(acc_q === e_acc, {cur_req, "/R8 acc"}, int'(acc_q), int'(e_acc));
    check(cnt_q === e_cnt, {cur_req, "/R9 cnt"}, int'(cnt_q), int'(e_cnt));
    check(dump_vld === e_vld, {cur_req, "/R10 vld"}, int'(dump_vld), int'(e_vld));
  endtask

  // drive one cycle at negedge, model the coming posedge, check at next negedge
  task automatic step(bit en, bit s, bit m, bit [1:0] cl, bit chip, bit d);
    logic signed [ACC_W-1:0] sum;
    smp_en = en; smp_sign = s; smp_mag = m; carr_lvl = cl; code_chip = chip; dump = d;
    sum = m_acc + (en ? ACC_W'(ref_prod(s, m, mon_mode, cl, carr_mix_off, chip, code_off)) : '0);
    if (d) begin
      e_acc = sum; e_cnt = m_cnt + CNT_W'(en); e_vld = 1'b1;
      m_acc = '0; m_cnt = '0;
    end else begin
      e_vld = 1'b0; m_acc = sum; m_cnt = m_cnt + CNT_W'(en);
    end
    @(negedge clk);
    check_outputs();
  endtask

  task automatic run_period(int len, int en_pct);
    for (int i = 0; i < len; i++)
      step(($urandom % 100) < en_pct, $urandom, $urandom, 2'($urandom), $urandom, i == len - 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    rst_n = 1'b0; smp_en = 0; smp_sign = 0; smp_mag = 0; carr_lvl = 0;
    carr_mix_off = 1; code_chip = 1; code_off = 1; mon_mode = 2'b00; dump = 0;
    m_acc = '0; m_cnt = '0; e_acc = '0; e_cnt = '0; e_vld = 0;
    repeat (3) @(negedge clk);
    check(acc_q === '0 && cnt_q === '0 && dump_vld === 1'b0, "R1 in reset", int'(acc_q), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(acc_q === '0 && cnt_q === '0 && dump_vld === 1'b0, "R1 after release", int'(acc_q), 0);

    cur_req = "R2/R5";
    mon_mode = 2'b00; carr_mix_off = 1; code_off = 1;
    for (int p = 0; p < 6; p++) run_period(20 + $urandom % 40, 100);
    mon_mode = 2'b11;
    for (int p = 0; p < 3; p++) run_period(25, 100);

    cur_req = "R3";
    mon_mode = 2'b00; carr_mix_off = 0;
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 10; i++) step(1, 1, 1, 2'(c), 1, i == 9);
    end
    for (int p = 0; p < 5; p++) run_period(30, 100);

    cur_req = "R4";
    carr_mix_off = 1; code_off = 0;
    for (int i = 0; i < 8; i++) step(1, 1, 0, 2'b11, 0, i == 7);
    for (int p = 0; p < 4; p++) run_period(30, 100);
    code_off = 1;
    for (int i = 0; i < 8; i++) step(1, 1, 0, 2'b11, 0, i == 7);

    cur_req = "R6";
    mon_mode = 2'b01; carr_mix_off = 1; code_off = 1;
    for (int i = 0; i < 12; i++) step(1, i < 5, 1, 2'b11, 0, i == 11);
    for (int p = 0; p < 6; p++) run_period(40 + $urandom % 60, 100);

    cur_req = "R7";
    mon_mode = 2'b10;
    for (int i = 0; i < 60; i++) step(1, 0, 1, 2'b10, 0, i == 59);
    for (int i = 0; i < 20; i++) step(1, 1, i[0], 2'b10, 0, i == 19);
    for (int p = 0; p < 6; p++) run_period(40 + $urandom % 60, 100);

    cur_req = "R8";
    mon_mode = 2'b00; carr_mix_off = 0; code_off = 0;
    step(1, 1, 1, 2'b01, 1, 1);
    step(1, 0, 1, 2'b00, 1, 1);
    step(1, 1, 0, 2'b11, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 2'b01, 1, 0);

    cur_req = "R11";
    step(0, 1, 1, 2'b01, 1, 1);
    for (int p = 0; p < 6; p++) run_period(10 + $urandom % 50, 40);

    cur_req = "R9";
    for (int p = 0; p < 40; p++) begin
      mon_mode = 2'($urandom); carr_mix_off = $urandom; code_off = $urandom;
      run_period(1 + $urandom % 120, 70);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule